// File: doc/BRIEF.md
# Counter write coalescing queue

This block is the persistent write queue of an encrypted memory controller. Each line write from the cache arrives as a pair: the encrypted data line and the counter line that holds the encryption counters of that line's page. A page is 64 lines, and one 64-byte counter line holds one shared major counter and 64 per-line minor counters for the whole page. An accepted pair is treated as durable at once, so the data and its counter always enter the queue in the same cycle.

Writes that stay within one page would otherwise send one counter line to memory per data line. Each newer counter line for a page already contains every earlier minor-counter update, so the queue invalidates any older pending counter entry of the same page when a new pair is accepted. Surviving entries drain in arrival order through a valid/ready port. Invalidated slots are discarded at the head without being shown.

Top module: `cwc_write_queue`

## Requirements
- R1: After reset the queue is empty: `occ_count` is 0, `deq_valid` is 0 and `enq_ready` is 1.
- R2: An accepted pair takes two slots in one cycle. The data entry (`deq_is_ctr`=0) leaves before its counter entry (`deq_is_ctr`=1), and `occ_count` rises by 2.
- R3: Two pages match when their data addresses agree in all bits above the low 6 line-in-page bits. An accepted pair invalidates every older, live counter entry whose page matches the new pair's page. When four lines of one page are enqueued back to back, draining yields the four data entries and only the last counter entry, 5 entries in total.
- R4: The entry at the head of the queue is never invalidated, even if a matching pair is accepted while it waits on the output.
- R5: `enq_ready` is 1 exactly when at least 2 slots are unoccupied. A refused pair changes nothing.
- R6: Live entries leave in arrival order, one per cycle with `deq_valid` and `deq_ready` both high. An invalidated entry at the head is dropped in one cycle while `deq_valid` stays 0.
- R7: `occ_count` counts every held slot, including invalidated slots that have not yet reached the head.
- R8: Data entries, and counter entries of other pages, are never invalidated and leave with the address and payload they were given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | A data/counter pair is offered |
| enq_ready | output | 1 | Room for a pair |
| enq_data_addr | input | ADDR_W | Line address of the data write |
| enq_data_payload | input | PAY_W | Data line contents |
| enq_ctr_addr | input | ADDR_W | Address of the page's counter line |
| enq_ctr_payload | input | PAY_W | Counter line contents |
| deq_valid | output | 1 | Head entry is live and offered |
| deq_ready | input | 1 | Memory side takes the head entry |
| deq_is_ctr | output | 1 | 1 for a counter entry, 0 for a data entry |
| deq_addr | output | ADDR_W | Address of the head entry |
| deq_payload | output | PAY_W | Payload of the head entry |
| occ_count | output | $clog2(DEPTH+1) | Slots held, including invalidated ones |

## Verification
Coalescing of an older counter entry and the dequeue of the head can fall in the same cycle, as can the dequeue of a counter entry and the arrival of a matching pair. The bench provokes both by drawing pages from a pool of three and toggling `deq_ready` at random, and adds directed cases where the matching counter entry sits at the head. A cycle-level reference queue in the bench, built from the requirements, fixes which entries survive. Each output beat and each `occ_count` value is compared against it.

// File: rtl/cwc_write_queue.sv
module cwc_write_queue #(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 32,
  parameter int PAY_W     = 512,
  parameter int LINE_BITS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  output logic                       enq_ready,
  input  logic [ADDR_W-1:0]          enq_data_addr,
  input  logic [PAY_W-1:0]           enq_data_payload,
  input  logic [ADDR_W-1:0]          enq_ctr_addr,
  input  logic [PAY_W-1:0]           enq_ctr_payload,
  output logic                       deq_valid,
  input  logic                       deq_ready,
  output logic                       deq_is_ctr,
  output logic [ADDR_W-1:0]          deq_addr,
  output logic [PAY_W-1:0]           deq_payload,
  output logic [$clog2(DEPTH+1)-1:0] occ_count
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic [DEPTH-1:0] is_ctr, live, stale;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PAY_W-1:0]  pay_q  [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  head, tail, tail_nx;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  new_tag;
  logic accept, pop;

  assign new_tag   = enq_data_addr[ADDR_W-1:LINE_BITS];
  assign tail_nx   = tail + PTR_W'(1);
  assign enq_ready = count <= CNT_W'(DEPTH - 2);
  assign accept    = enq_valid && enq_ready;
  assign deq_valid = (count != '0) && live[head];
  assign pop       = (count != '0) && (!live[head] || deq_ready);
  assign deq_is_ctr  = is_ctr[head];
  assign deq_addr    = addr_q[head];
  assign deq_payload = pay_q[head];
  assign occ_count   = count;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    logic [PTR_W-1:0] off;
    assign off = PTR_W'(g) - head;
    assign stale[g] = (CNT_W'(off) < count) && (off != '0) &&
                      is_ctr[g] && live[g] && (tag_q[g] == new_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      live  <= '0;
    end else begin
      if (accept) begin
        live          <= (live & ~stale);
        live[tail]    <= 1'b1;
        live[tail_nx] <= 1'b1;
        tail          <= tail + PTR_W'(2);
      end
      if (pop) head <= head + PTR_W'(1);
      count <= count + (accept ? CNT_W'(2) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      is_ctr[tail]    <= 1'b0;
      addr_q[tail]    <= enq_data_addr;
      pay_q[tail]     <= enq_data_payload;
      tag_q[tail]     <= new_tag;
      is_ctr[tail_nx] <= 1'b1;
      addr_q[tail_nx] <= enq_ctr_addr;
      pay_q[tail_nx]  <= enq_ctr_payload;
      tag_q[tail_nx]  <= new_tag;
    end
  end
endmodule

module cwc_write_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enq_valid,
  input logic                       enq_ready,
  input logic                       deq_valid,
  input logic                       deq_ready,
  input logic                       deq_is_ctr,
  input logic [ADDR_W-1:0]          deq_addr,
  input logic [$clog2(DEPTH+1)-1:0] occ_count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_count <= ($clog2(DEPTH+1))'(DEPTH)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_count) <= 32'($past(occ_count)) + 2); // R2
  AST_REFUSED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && !enq_ready |=> occ_count <= $past(occ_count)); // R5
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && !deq_ready |=> deq_valid && $stable(deq_addr) && $stable(deq_is_ctr)); // R4
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    occ_count == '0 |-> !deq_valid); // R6
endmodule

bind cwc_write_queue cwc_write_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_is_ctr(deq_is_ctr),
  .deq_addr(deq_addr), .occ_count(occ_count));

// File: tb/tb_cwc_write_queue.sv
module tb_cwc_write_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int PW = 512;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, deq_ready = 0;
  logic [AW-1:0] enq_data_addr = '0, enq_ctr_addr = '0;
  logic [PW-1:0] enq_data_payload = '0, enq_ctr_payload = '0;
  logic enq_ready, deq_valid, deq_is_ctr;
  logic [AW-1:0] deq_addr;
  logic [PW-1:0] deq_payload;
  logic [4:0] occ_count;

  int checks = 0, errors = 0;
  bit done = 0;

  bit            mq_ctr[$];
  bit            mq_live[$];
  logic [AW-1:0] mq_addr[$];
  logic [PW-1:0] mq_pay[$];
  logic [25:0]   mq_tag[$];
  logic [AW-1:0] log_addr[$];
  bit            log_ctr[$];
  logic [PW-1:0] log_pay[$];

  cwc_write_queue dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mkpay();
    logic [PW-1:0] p;
    for (int k = 0; k < PW/32; k++) p[k*32 +: 32] = $urandom();
    return p;
  endfunction

  // one cycle: drive at negedge, compare with model, advance model and clock
  task automatic step(input bit v, input bit rdy, input logic [AW-1:0] da);
    int n = mq_ctr.size();
    bit exp_valid, acc, pp;
    logic [AW-1:0] ca = 32'h8000_0000 | AW'(da[AW-1:6]);
    logic [PW-1:0] dp = mkpay(), cp = mkpay();
    enq_valid = v; deq_ready = rdy; enq_data_addr = da; enq_ctr_addr = ca;
    enq_data_payload = dp; enq_ctr_payload = cp;
    #1;
    exp_valid = n > 0 && mq_live[0];
    chk(occ_count == 5'(n), "R7 occupancy", longint'(occ_count), longint'(n));
    chk(enq_ready == (DEPTH - n >= 2), "R5 ready", longint'(enq_ready), longint'(DEPTH - n >= 2));
    chk(deq_valid == exp_valid, "R6 valid", longint'(deq_valid), longint'(exp_valid));
    if (exp_valid && deq_valid) begin
      chk(deq_addr == mq_addr[0], "R6 R8 order/addr", longint'(deq_addr), longint'(mq_addr[0]));
      chk(deq_is_ctr == mq_ctr[0], "R2 type", longint'(deq_is_ctr), longint'(mq_ctr[0]));
      chk(deq_payload == mq_pay[0], "R8 payload", longint'(deq_payload[63:0]), longint'(mq_pay[0][63:0]));
    end
    acc = v && (DEPTH - n >= 2);
    pp = n > 0 && (!mq_live[0] || rdy);
    if (exp_valid && rdy) begin
      log_addr.push_back(mq_addr[0]); log_ctr.push_back(mq_ctr[0]); log_pay.push_back(mq_pay[0]);
    end
    if (acc)
      for (int i = 1; i < n; i++)
        if (mq_ctr[i] && mq_live[i] && mq_tag[i] == da[AW-1:6]) mq_live[i] = 0;
    if (pp) begin
      void'(mq_ctr.pop_front()); void'(mq_live.pop_front()); void'(mq_addr.pop_front());
      void'(mq_pay.pop_front()); void'(mq_tag.pop_front());
    end
    if (acc) begin
      mq_ctr.push_back(0); mq_live.push_back(1); mq_addr.push_back(da); mq_pay.push_back(dp); mq_tag.push_back(da[AW-1:6]);
      mq_ctr.push_back(1); mq_live.push_back(1); mq_addr.push_back(ca); mq_pay.push_back(cp); mq_tag.push_back(da[AW-1:6]);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 64 && mq_ctr.size() > 0; k++) step(0, 1, '0);
  endtask

  task automatic clear_log();
    log_addr.delete(); log_ctr.delete(); log_pay.delete();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    #1;
    // R1 reset state
    chk(occ_count == 0, "R1 count", longint'(occ_count), 0);
    chk(deq_valid == 0, "R1 valid", longint'(deq_valid), 0);
    chk(enq_ready == 1, "R1 ready", longint'(enq_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // R3 four lines of one page, output stalled
    clear_log();
    for (int l = 0; l < 4; l++) step(1, 0, {26'h0001, 6'(l)});
    chk(occ_count == 8, "R2 R7 two slots per pair", longint'(occ_count), 8);
    drain();
    chk(log_addr.size() == 5, "R3 four data plus one counter", log_addr.size(), 5);
    if (log_addr.size() == 5) begin
      chk(log_ctr[4] == 1, "R3 last is counter", longint'(log_ctr[4]), 1);
      chk(log_ctr[3] == 0 && log_addr[3] == {26'h0001, 6'd3}, "R3 fourth data", longint'(log_addr[3]), longint'({26'h0001, 6'd3}));
    end

    // R4 counter at head survives a matching pair
    clear_log();
    step(1, 0, {26'h0005, 6'd1});
    step(0, 1, '0);
    step(1, 0, {26'h0005, 6'd2});
    drain();
    chk(log_addr.size() == 4, "R4 head counter kept", log_addr.size(), 4);
    if (log_addr.size() == 4) chk(log_ctr[1] == 1, "R4 head counter order", longint'(log_ctr[1]), 1);

    // R5 R7 fill with one page: invalidated slots still count
    clear_log();
    for (int l = 0; l < 8; l++) step(1, 0, {26'h0009, 6'(l)});
    chk(occ_count == 16, "R7 full with dead slots", longint'(occ_count), 16);
    chk(enq_ready == 0, "R5 full refuses", longint'(enq_ready), 0);
    step(1, 0, {26'h000A, 6'd0});
    chk(occ_count == 16, "R5 refused pair ignored", longint'(occ_count), 16);
    drain();
    chk(log_addr.size() == 9, "R6 dead slots skipped", log_addr.size(), 9);

    // random mix with a small page pool
    for (int c = 0; c < 4000; c++)
      step(($urandom() % 3) != 0, ($urandom() % 2) == 1,
           {26'($urandom() % 3 + 32), 6'($urandom() % 64)});
    drain();
    chk(occ_count == 0, "R6 drained", longint'(occ_count), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule